// File: doc/BRIEF.md
# Eight-Cell Accumulator Readout Selector

This block sits beside a bank of eight 26-bit cell accumulators. It picks which cell is read out, freezes that reading, and issues the clear strobes for the bank. A 3-bit cell address is registered one clock before it is used. When the registered address changes, the addressed accumulator is copied into a capture register on the following clock. That copy is held for as long as the address stays the same, so a slow reader sees a stable word even while the cell keeps accumulating.

A registered select chooses what is presented: the captured cell value or a combined output-stage sum computed elsewhere. The 26-bit result leaves on two fields, an upper 10-bit field and a lower 16-bit field. Each field has its own active-low enable and a valid flag. A disabled field drives zeros in place of a high-impedance state.

An active-low erase produces a one-hot clear strobe for the addressed accumulator. When erase coincides with the registered control clear, it produces a clear strobe for every accumulator. The control clear also empties the capture register.

Top module: `acc_readout_sel`

## Requirements
- R1: The address input is registered, so an address change reaches the clear strobes one clock after it is presented.
- R2: On the first clock after the registered address takes a new value, the capture register loads the accumulator that the registered address selects, as it stands at that clock. After reset, the first clock captures cell 0.
- R3: While the registered address stays unchanged, the capture register holds its value even if the addressed accumulator changes.
- R4: With erase low and the registered control clear high, the clear strobe is one-hot: bit n is set when the registered address equals n.
- R5: With erase low and the registered control clear low, all eight clear strobe bits are 1.
- R6: With erase high, the clear strobe is all zeros.
- R7: The upper field carries result bits 25..16 while its enable is low, and drives zero otherwise. Its valid flag equals the inverse of the enable.
- R8: The lower field carries result bits 15..0 while its enable is low, and drives zero otherwise. Its valid flag equals the inverse of the enable.
- R9: The output-stage select is registered. When the registered select is 1, the result is the output-stage sum input; when it is 0, the result is the capture register.
- R10: The control clear input is registered. While the registered clear is low, the capture register is set to zero. On the first clock after it returns high, the addressed cell is captured again.
- R11: After reset the capture register is zero and the registered select is 0, so the enabled fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_i | input | 3 | Cell address |
| stage_sel_i | input | 1 | 1 selects the output-stage sum, 0 selects the captured cell |
| ctl_clr_n_i | input | 1 | Active-low control clear (registered) |
| erase_n_i | input | 1 | Active-low accumulator erase |
| acc_i | input | 208 | Eight accumulators; cell n occupies bits 26n+25..26n |
| stage_sum_i | input | 26 | Output-stage sum |
| en_hi_n_i | input | 1 | Active-low enable of the upper field |
| en_lo_n_i | input | 1 | Active-low enable of the lower field |
| sum_hi_o | output | 10 | Result bits 25..16, or zero when disabled |
| sum_lo_o | output | 16 | Result bits 15..0, or zero when disabled |
| vld_hi_o | output | 1 | Upper field enabled |
| vld_lo_o | output | 1 | Lower field enabled |
| clr_mask_o | output | 8 | Per-cell clear strobes |

## Verification
The hardest case to reach is the freeze. The addressed accumulator must keep changing while the address holds, and then the address must change twice in a row so that captures land on back-to-back clocks. The bench drives every accumulator with a value that encodes both the cell and the current step. Any premature or missed capture therefore shows up as a wrong cell or a wrong step in the result. A walked vector table also lays address changes, field enables and the output-stage select over one another, so that the two-clock path from address to captured word is exercised under each combination.

// File: rtl/rdsel_pkg.sv
package rdsel_pkg;
  localparam int unsigned CELLS = 8;
  localparam int unsigned DW    = 26;
  localparam int unsigned HIW   = 10;
  localparam int unsigned LOW   = DW - HIW;
  localparam int unsigned AW    = $clog2(CELLS);

  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/rdsel_ctl.sv
module rdsel_ctl #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] adr_i,
  input  logic          stage_sel_i,
  input  logic          ctl_clr_n_i,
  output logic [AW-1:0] adr_q,
  output logic          stage_sel_q,
  output logic          clr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q       <= '0;
      stage_sel_q <= 1'b0;
      clr_q       <= 1'b1;
    end else begin
      adr_q       <= adr_i;
      stage_sel_q <= stage_sel_i;
      clr_q       <= ctl_clr_n_i;
    end
  end
endmodule

// File: rtl/rdsel_capture.sv
module rdsel_capture #(
  parameter int unsigned CELLS = 8,
  parameter int unsigned DW    = 26,
  localparam int unsigned AW   = $clog2(CELLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_q,
  input  logic [AW-1:0]       adr_q,
  input  logic [CELLS*DW-1:0] acc_flat,
  output logic [DW-1:0]       cap_o,
  output logic                new_sel_o
);
  logic [AW-1:0] adr_prev;
  logic          prime;
  logic [DW-1:0] sel_val;

  assign sel_val   = acc_flat[adr_q*DW +: DW];
  assign new_sel_o = prime | (adr_q != adr_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_prev <= '0;
      prime    <= 1'b1;
      cap_o    <= '0;
    end else begin
      adr_prev <= adr_q;
      if (!clr_q) begin
        cap_o <= '0;
        prime <= 1'b1;
      end else if (new_sel_o) begin
        cap_o <= sel_val;
        prime <= 1'b0;
      end
    end
  end

  assert_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && new_sel_o) |=> cap_o == $past(sel_val));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !new_sel_o) |=> $stable(cap_o));
  assert_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> cap_o == '0);
endmodule

// File: rtl/rdsel_clear.sv
module rdsel_clear #(
  parameter int unsigned CELLS = 8,
  localparam int unsigned AW   = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_n,
  input  logic             clr_q,
  input  logic [AW-1:0]    adr_q,
  output logic [CELLS-1:0] mask_o
);
  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assign mask_o[c] = !erase_n && (!clr_q || (adr_q == AW'(c)));
  end

  assert_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_n && clr_q) |-> ($countones(mask_o) == 1 && mask_o[adr_q]));
  assert_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_n && !clr_q) |-> (&mask_o));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_n |-> mask_o == '0);
endmodule

// File: rtl/rdsel_field.sv
module rdsel_field #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val_i,
  input  logic         en_n,
  output logic [W-1:0] field_o,
  output logic         vld_o
);
  assign vld_o   = ~en_n;
  assign field_o = en_n ? '0 : val_i;

  assert_off_zero_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> field_o == '0);
endmodule

// File: rtl/acc_readout_sel.sv
module acc_readout_sel
  import rdsel_pkg::*;
#(
  parameter int unsigned NCELL = CELLS,
  parameter int unsigned WORD  = DW,
  parameter int unsigned HI_W  = HIW,
  localparam int unsigned LO_W = WORD - HI_W,
  localparam int unsigned A_W  = $clog2(NCELL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [A_W-1:0]        adr_i,
  input  logic                  stage_sel_i,
  input  logic                  ctl_clr_n_i,
  input  logic                  erase_n_i,
  input  logic [NCELL*WORD-1:0] acc_i,
  input  logic [WORD-1:0]       stage_sum_i,
  input  logic                  en_hi_n_i,
  input  logic                  en_lo_n_i,
  output logic [HI_W-1:0]       sum_hi_o,
  output logic [LO_W-1:0]       sum_lo_o,
  output logic                  vld_hi_o,
  output logic                  vld_lo_o,
  output logic [NCELL-1:0]      clr_mask_o
);
  logic [A_W-1:0]  adr_q;
  logic            stage_sel_q;
  logic            clr_q;
  logic [WORD-1:0] cap;
  logic            new_sel;
  logic [WORD-1:0] result;

  rdsel_ctl #(.AW(A_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .adr_i(adr_i), .stage_sel_i(stage_sel_i),
    .ctl_clr_n_i(ctl_clr_n_i), .adr_q(adr_q), .stage_sel_q(stage_sel_q),
    .clr_q(clr_q)
  );

  rdsel_capture #(.CELLS(NCELL), .DW(WORD)) i_cap (
    .clk(clk), .rst_n(rst_n), .clr_q(clr_q), .adr_q(adr_q),
    .acc_flat(acc_i), .cap_o(cap), .new_sel_o(new_sel)
  );

  rdsel_clear #(.CELLS(NCELL)) i_clr (
    .clk(clk), .rst_n(rst_n), .erase_n(erase_n_i), .clr_q(clr_q),
    .adr_q(adr_q), .mask_o(clr_mask_o)
  );

  assign result = stage_sel_q ? stage_sum_i : cap;

  for (genvar g = 0; g < 2; g++) begin : g_fld
    if (g == 0) begin : g_lo
      rdsel_field #(.W(LO_W)) i_fld (
        .clk(clk), .rst_n(rst_n), .val_i(result[LO_W-1:0]), .en_n(en_lo_n_i),
        .field_o(sum_lo_o), .vld_o(vld_lo_o)
      );
    end else begin : g_hi
      rdsel_field #(.W(HI_W)) i_fld (
        .clk(clk), .rst_n(rst_n), .val_i(result[WORD-1:LO_W]), .en_n(en_hi_n_i),
        .field_o(sum_hi_o), .vld_o(vld_hi_o)
      );
    end
  end

  assert_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_sel_q && !en_hi_n_i && !en_lo_n_i) |-> {sum_hi_o, sum_lo_o} == stage_sum_i);
endmodule

// File: tb/test_acc_readout_sel.sv
`timescale 1ns/1ps
module test_acc_readout_sel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   adr_i = '0;
  logic         stage_sel_i = 1'b0;
  logic         ctl_clr_n_i = 1'b1;
  logic         erase_n_i = 1'b1;
  logic [207:0] acc_i = '0;
  logic [25:0]  stage_sum_i = '0;
  logic         en_hi_n_i = 1'b0;
  logic         en_lo_n_i = 1'b0;
  logic [9:0]   sum_hi_o;
  logic [15:0]  sum_lo_o;
  logic         vld_hi_o, vld_lo_o;
  logic [7:0]   clr_mask_o;

  int errors = 0;
  int checks = 0;
  int st = 0;

  always #4 clk = ~clk;

  acc_readout_sel i_acc_readout_sel (
    .clk(clk), .rst_n(rst_n), .adr_i(adr_i), .stage_sel_i(stage_sel_i),
    .ctl_clr_n_i(ctl_clr_n_i), .erase_n_i(erase_n_i), .acc_i(acc_i),
    .stage_sum_i(stage_sum_i), .en_hi_n_i(en_hi_n_i), .en_lo_n_i(en_lo_n_i),
    .sum_hi_o(sum_hi_o), .sum_lo_o(sum_lo_o), .vld_hi_o(vld_hi_o),
    .vld_lo_o(vld_lo_o), .clr_mask_o(clr_mask_o)
  );

  // cell value encodes cell number (upper bits) and step (lower bits)
  function automatic logic [25:0] cellv(int c, int s);
    return 26'(c << 20) | 26'(s * 7 + 1);
  endfunction
  function automatic logic [25:0] stagev(int s);
    return 26'h2AAAAAA ^ 26'(s);
  endfunction

  // row: {adr[3], sel, en_hi_n, en_lo_n, exp_cell[3], exp_step[5]}
  localparam logic [13:0] TBL [14] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0},
    {3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0},
    {3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0},
    {3'd3, 1'b0, 1'b1, 1'b0, 3'd3, 5'd3},
    {3'd3, 1'b1, 1'b0, 1'b0, 3'd3, 5'd3},
    {3'd3, 1'b0, 1'b0, 1'b1, 3'd3, 5'd3},
    {3'd5, 1'b0, 1'b0, 1'b0, 3'd3, 5'd3},
    {3'd6, 1'b0, 1'b0, 1'b0, 3'd5, 5'd7},
    {3'd6, 1'b0, 1'b0, 1'b0, 3'd6, 5'd8},
    {3'd6, 1'b1, 1'b0, 1'b0, 3'd6, 5'd8},
    {3'd7, 1'b0, 1'b0, 1'b0, 3'd6, 5'd8},
    {3'd1, 1'b0, 1'b0, 1'b0, 3'd7, 5'd11},
    {3'd1, 1'b0, 1'b0, 1'b0, 3'd1, 5'd12},
    {3'd1, 1'b0, 1'b1, 1'b1, 3'd1, 5'd12}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_accs();
    for (int c = 0; c < 8; c++) acc_i[c*26 +: 26] = cellv(c, st);
    stage_sum_i = stagev(st);
  endtask

  // drive at falling edge, then cross one rising edge and settle
  task automatic tick();
    @(posedge clk);
    #1;
    st++;
    @(negedge clk);
    drive_accs();
  endtask

  task automatic chk_fields(input string req, input logic [25:0] v, input bit eh, input bit el);
    logic [27:0] exp, act;
    exp = {~eh, ~el, (eh ? 10'd0 : v[25:16]), (el ? 16'd0 : v[15:0])};
    act = {vld_hi_o, vld_lo_o, sum_hi_o, sum_lo_o};
    chk(act == exp, req, 32'(act), 32'(exp));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [25:0] ev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    drive_accs();
    #1;
    // R11: reset state, both fields enabled
    chk({sum_hi_o, sum_lo_o} == 26'd0, "R11 reset result", 32'({sum_hi_o, sum_lo_o}), 0);
    chk(clr_mask_o == 8'h00, "R11 R6 reset mask", 32'(clr_mask_o), 0);

    // vector table walk: R2 R3 R7 R8 R9 R6
    for (int s = 0; s < 14; s++) begin
      adr_i       = TBL[s][13:11];
      stage_sel_i = TBL[s][10];
      en_hi_n_i   = TBL[s][9];
      en_lo_n_i   = TBL[s][8];
      rst_n       = 1'b1;
      ev = TBL[s][10] ? stagev(s) : cellv(int'(TBL[s][7:5]), int'(TBL[s][4:0]));
      @(posedge clk);
      #1;
      chk_fields($sformatf("R2 R3 R7 R8 R9 row %0d", s), ev, TBL[s][9], TBL[s][8]);
      chk(clr_mask_o == 8'h00, "R6 mask idle", 32'(clr_mask_o), 0);
      st++;
      @(negedge clk);
      drive_accs();
    end
    en_hi_n_i = 1'b0;
    en_lo_n_i = 1'b0;
    stage_sel_i = 1'b0;

    // R4: registered address is 1
    erase_n_i = 1'b0;
    #1;
    chk(clr_mask_o == 8'h02, "R4 one-hot clear", 32'(clr_mask_o), 32'h02);

    // R1: new address visible on mask only after the edge
    adr_i = 3'd2;
    #1;
    chk(clr_mask_o == 8'h02, "R1 before edge", 32'(clr_mask_o), 32'h02);
    tick();
    chk(clr_mask_o == 8'h04, "R1 R4 after edge", 32'(clr_mask_o), 32'h04);
    erase_n_i = 1'b1;
    tick();

    // R5 / R10: control clear registered
    ctl_clr_n_i = 1'b0;
    #1;
    chk(clr_mask_o == 8'h00, "R6 clear with erase high", 32'(clr_mask_o), 0);
    tick();
    erase_n_i = 1'b0;
    #1;
    chk(clr_mask_o == 8'hFF, "R5 all clear", 32'(clr_mask_o), 32'hFF);
    tick();
    chk({sum_hi_o, sum_lo_o} == 26'd0, "R10 capture zeroed", 32'({sum_hi_o, sum_lo_o}), 0);
    ctl_clr_n_i = 1'b1;
    erase_n_i = 1'b1;
    tick();
    chk({sum_hi_o, sum_lo_o} == 26'd0, "R10 still zero on release edge", 32'({sum_hi_o, sum_lo_o}), 0);
    ev = cellv(2, st);
    @(posedge clk);
    #1;
    chk({sum_hi_o, sum_lo_o} == ev, "R10 recapture", 32'({sum_hi_o, sum_lo_o}), 32'(ev));
    st++;
    @(negedge clk);
    drive_accs();
    tick();
    chk({sum_hi_o, sum_lo_o} == ev, "R3 hold after recapture", 32'({sum_hi_o, sum_lo_o}), 32'(ev));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule